// File: doc/BRIEF.md
# Parallel-Lane Ternary Gate Evaluator with Fault Injection

This block evaluates one two-input primitive gate (AND, OR, NAND or NOR) for `LANES` copies of a circuit at once. Each lane is one simulated machine. A signal is carried as two words of `LANES` bits each. The value word holds the logic level of each lane. The unknown word holds one flag per lane, and a set flag marks that lane as X. Lane 0 is the fault-free reference machine. Every other lane may carry injected defects.

Defects are applied to all lanes in a single pass. Each injection point takes a pair of mask words, and the two bits at the same position select no fault, stuck-at-X, stuck-at-0 or stuck-at-1 for that lane. There is an injection point on each operand pin and one on the gate output. The pin faults alter only the operand copy used by this evaluation. A lane can also carry a functional fault, which replaces its result with the result of a substitute gate type before the output masks act. Faults placed on the same lane across several injection points model one machine with several defects.

The unit has a single result register. Operands enter through a valid/ready handshake and results leave through a second one. A result is offered one cycle after it is accepted. While a result is waiting and `out_ready` is low, the block accepts no new operands and holds the waiting result unchanged. When `out_ready` is high, a new operand set can be accepted in the same cycle that the old result leaves, so the unit sustains one evaluation per cycle.

Top module: `tern_gate_eval`

## Requirements
- R1: A lane whose unknown flag is 1 is treated as X whatever its value bit is. Every offered result is canonical: in any lane whose unknown flag is 1, the value bit is 0.
- R2: With `gate_sel`=0 (AND), a lane's result is 0 if either operand is known 0. Otherwise it is X if either operand is X. Otherwise it is 1.
- R3: With `gate_sel`=1 (OR), a lane's result is 1 if either operand is known 1. Otherwise it is X if either operand is X. Otherwise it is 0.
- R4: `gate_sel`=2 (NAND) and `gate_sel`=3 (NOR) give the complement of AND and OR. A known level is inverted and X stays X.
- R5: At each operand pin, the mask bits (m1,m2) of a lane act as follows: (0,0) leaves the operand unchanged, (0,1) forces it to X, (1,0) forces it to 0 and (1,1) forces it to 1. Each lane is decoded on its own.
- R6: The output masks `y_m1`/`y_m2` use the same encoding as R5. They act on the result after any functional substitution, so an output stuck-at wins over a functional fault.
- R7: In every lane whose bit in `fn_lanes` is set, the result is computed with the substitute gate `fn_sel` (same codes as `gate_sel`) from that lane's faulted operands.
- R8: Lane 0 ignores every mask bit and `fn_lanes` bit. It always shows the fault-free result.
- R9: An operand set accepted on a clock edge (`in_valid` and `in_ready` both high) is offered with `out_valid` high after that edge. Results leave in the order their operands were accepted.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `y_val` and `y_unk` hold. After reset, `out_valid` is 0.
- R11: Faults on different injection points that share a lane all act on that lane together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set is presented |
| in_ready | output | 1 | Operand set will be accepted on this edge |
| gate_sel | input | 2 | Gate type: 0 AND, 1 OR, 2 NAND, 3 NOR |
| a_val | input | LANES | Operand A value word |
| a_unk | input | LANES | Operand A unknown-flag word |
| b_val | input | LANES | Operand B value word |
| b_unk | input | LANES | Operand B unknown-flag word |
| a_m1 | input | LANES | Pin A fault mask, first word |
| a_m2 | input | LANES | Pin A fault mask, second word |
| b_m1 | input | LANES | Pin B fault mask, first word |
| b_m2 | input | LANES | Pin B fault mask, second word |
| fn_lanes | input | LANES | Lanes carrying a functional fault |
| fn_sel | input | 2 | Substitute gate type for functional-fault lanes |
| y_m1 | input | LANES | Output fault mask, first word |
| y_m2 | input | LANES | Output fault mask, second word |
| out_valid | output | 1 | Result is offered |
| out_ready | input | 1 | Consumer takes the result on this edge |
| y_val | output | LANES | Result value word |
| y_unk | output | LANES | Result unknown-flag word |

## Verification
Most internal faults in this block show up at the ports in the first cycle after the bad data is accepted, because the path from operands to `y_val`/`y_unk` passes through only one register. A bad decode of the masks, or a mistake in the injection order, shows up at once as a wrong lane in the next offered result. The same holds for a lane-0 guard that leaks a fault, or for a gate equation that mishandles X. A result register that is not canonical shows as a lane with both bits set. A fault in the handshake register shows up as a lost, repeated or changed result during the first stall. It also shows as an `in_ready` that disagrees with `out_valid` and `out_ready` in that same cycle.

// File: rtl/tge_pkg.sv
package tge_pkg;
  typedef enum logic [1:0] {
    GATE_AND  = 2'd0,
    GATE_OR   = 2'd1,
    GATE_NAND = 2'd2,
    GATE_NOR  = 2'd3
  } gate_op_e;
endpackage

// File: rtl/tge_fault_inject.sv
// Per-lane stuck-at injection from a pair of mask words; result is canonical.
module tge_fault_inject #(
  parameter int LANES = 16,
  parameter bit GUARD_LANE0 = 1'b1
) (
  input  logic [LANES-1:0] sig_val,
  input  logic [LANES-1:0] sig_unk,
  input  logic [LANES-1:0] m1,
  input  logic [LANES-1:0] m2,
  output logic [LANES-1:0] f_val,
  output logic [LANES-1:0] f_unk
);
  localparam logic [LANES-1:0] ARMED =
    GUARD_LANE0 ? {{(LANES-1){1'b1}}, 1'b0} : {LANES{1'b1}};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic e1, e2, tv, tu;
    always_comb begin
      e1 = m1[i] & ARMED[i];
      e2 = m2[i] & ARMED[i];
      tv = (sig_val[i] & ~e1) | e2;
      tu = (sig_unk[i] & ~e1) | (e2 & ~e1);
      f_unk[i] = tu;
      f_val[i] = tv & ~tu;
    end
  end
endmodule

// File: rtl/tge_gate_core.sv
// Three-valued two-input gate on LANES lanes, word-parallel.
module tge_gate_core
  import tge_pkg::*;
#(
  parameter int LANES = 16
) (
  input  gate_op_e         op,
  input  logic [LANES-1:0] a_val,
  input  logic [LANES-1:0] a_unk,
  input  logic [LANES-1:0] b_val,
  input  logic [LANES-1:0] b_unk,
  output logic [LANES-1:0] g_val,
  output logic [LANES-1:0] g_unk
);
  logic [LANES-1:0] a_k0, a_k1, b_k0, b_k1, any_x;
  logic [LANES-1:0] and_v, and_u, or_v, or_u;

  always_comb begin
    a_k0  = ~a_val & ~a_unk;
    a_k1  =  a_val & ~a_unk;
    b_k0  = ~b_val & ~b_unk;
    b_k1  =  b_val & ~b_unk;
    any_x = a_unk | b_unk;
    and_u = any_x & ~a_k0 & ~b_k0;
    and_v = a_k1 & b_k1;
    or_u  = any_x & ~a_k1 & ~b_k1;
    or_v  = a_k1 | b_k1;
    unique case (op)
      GATE_AND:  begin g_val = and_v;           g_unk = and_u; end
      GATE_OR:   begin g_val = or_v;            g_unk = or_u;  end
      GATE_NAND: begin g_val = ~and_v & ~and_u; g_unk = and_u; end
      default:   begin g_val = ~or_v & ~or_u;   g_unk = or_u;  end
    endcase
  end
endmodule

// File: rtl/tge_fn_subst.sv
// Lane-wise choice between the normal and the substitute gate result.
module tge_fn_subst #(
  parameter int LANES = 16
) (
  input  logic [LANES-1:0] lanes,
  input  logic [LANES-1:0] norm_val,
  input  logic [LANES-1:0] norm_unk,
  input  logic [LANES-1:0] alt_val,
  input  logic [LANES-1:0] alt_unk,
  output logic [LANES-1:0] s_val,
  output logic [LANES-1:0] s_unk
);
  localparam logic [LANES-1:0] ARMED = {{(LANES-1){1'b1}}, 1'b0};
  logic [LANES-1:0] pick;

  always_comb begin
    pick  = lanes & ARMED;
    s_val = (norm_val & ~pick) | (alt_val & pick);
    s_unk = (norm_unk & ~pick) | (alt_unk & pick);
  end
endmodule

// File: rtl/tern_gate_eval.sv
module tern_gate_eval
  import tge_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       gate_sel,
  input  logic [LANES-1:0] a_val,
  input  logic [LANES-1:0] a_unk,
  input  logic [LANES-1:0] b_val,
  input  logic [LANES-1:0] b_unk,
  input  logic [LANES-1:0] a_m1,
  input  logic [LANES-1:0] a_m2,
  input  logic [LANES-1:0] b_m1,
  input  logic [LANES-1:0] b_m2,
  input  logic [LANES-1:0] fn_lanes,
  input  logic [1:0]       fn_sel,
  input  logic [LANES-1:0] y_m1,
  input  logic [LANES-1:0] y_m2,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LANES-1:0] y_val,
  output logic [LANES-1:0] y_unk
);
  localparam logic [LANES-1:0] FAULTABLE = {{(LANES-1){1'b1}}, 1'b0};

  logic [LANES-1:0] fa_val, fa_unk, fb_val, fb_unk;
  logic [LANES-1:0] n_val, n_unk, s_alt_val, s_alt_unk;
  logic [LANES-1:0] m_val, m_unk, r_val, r_unk;
  gate_op_e main_op, alt_op;

  assign main_op  = gate_op_e'(gate_sel);
  assign alt_op   = gate_op_e'(fn_sel);
  assign in_ready = !out_valid || out_ready;

  tge_fault_inject #(.LANES(LANES), .GUARD_LANE0(1'b1)) u_pin_a (
    .sig_val(a_val), .sig_unk(a_unk), .m1(a_m1), .m2(a_m2),
    .f_val(fa_val), .f_unk(fa_unk));

  tge_fault_inject #(.LANES(LANES), .GUARD_LANE0(1'b1)) u_pin_b (
    .sig_val(b_val), .sig_unk(b_unk), .m1(b_m1), .m2(b_m2),
    .f_val(fb_val), .f_unk(fb_unk));

  tge_gate_core #(.LANES(LANES)) u_core_main (
    .op(main_op), .a_val(fa_val), .a_unk(fa_unk), .b_val(fb_val), .b_unk(fb_unk),
    .g_val(n_val), .g_unk(n_unk));

  tge_gate_core #(.LANES(LANES)) u_core_alt (
    .op(alt_op), .a_val(fa_val), .a_unk(fa_unk), .b_val(fb_val), .b_unk(fb_unk),
    .g_val(s_alt_val), .g_unk(s_alt_unk));

  tge_fn_subst #(.LANES(LANES)) u_subst (
    .lanes(fn_lanes), .norm_val(n_val), .norm_unk(n_unk),
    .alt_val(s_alt_val), .alt_unk(s_alt_unk), .s_val(m_val), .s_unk(m_unk));

  tge_fault_inject #(.LANES(LANES), .GUARD_LANE0(1'b1)) u_pin_y (
    .sig_val(m_val), .sig_unk(m_unk), .m1(y_m1), .m2(y_m2),
    .f_val(r_val), .f_unk(r_unk));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      y_val     <= '0;
      y_unk     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        y_val <= r_val;
        y_unk <= r_unk;
      end
    end
  end

  p_canon_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((y_val & y_unk) == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(y_val) && $stable(y_unk)));

  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  p_out_sa1_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=>
      (((y_val & ~y_unk) & $past(y_m1 & y_m2 & FAULTABLE)) == $past(y_m1 & y_m2 & FAULTABLE)));

  p_out_sa0_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=>
      (((y_val | y_unk) & $past(y_m1 & ~y_m2 & FAULTABLE)) == '0));
endmodule

// File: tb/sim_tern_gate_eval.sv
module sim_tern_gate_eval;
  localparam int L = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] gate_sel = '0, fn_sel = '0;
  logic [L-1:0] a_val = '0, a_unk = '0, b_val = '0, b_unk = '0;
  logic [L-1:0] a_m1 = '0, a_m2 = '0, b_m1 = '0, b_m2 = '0;
  logic [L-1:0] fn_lanes = '0, y_m1 = '0, y_m2 = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [L-1:0] y_val, y_unk;

  int checks = 0, errors = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;
  logic [2*L-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  tern_gate_eval #(.LANES(L)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .gate_sel(gate_sel), .a_val(a_val), .a_unk(a_unk), .b_val(b_val), .b_unk(b_unk),
    .a_m1(a_m1), .a_m2(a_m2), .b_m1(b_m1), .b_m2(b_m2),
    .fn_lanes(fn_lanes), .fn_sel(fn_sel), .y_m1(y_m1), .y_m2(y_m2),
    .out_valid(out_valid), .out_ready(out_ready), .y_val(y_val), .y_unk(y_unk));

  task automatic check(bit ok, string tag, logic [2*L-1:0] act, logic [2*L-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scalar model: 0, 1, 2 = X
  function automatic int code(logic v, logic u);
    return u ? 2 : (v ? 1 : 0);
  endfunction
  function automatic int apply_mask(int v, logic m1, logic m2);
    case ({m1, m2})
      2'b00: return v;
      2'b01: return 2;
      2'b10: return 0;
      default: return 1;
    endcase
  endfunction
  function automatic int gate(int op, int a, int b);
    int r;
    if (op % 2 == 0) r = (a == 0 || b == 0) ? 0 : ((a == 2 || b == 2) ? 2 : 1);
    else             r = (a == 1 || b == 1) ? 1 : ((a == 2 || b == 2) ? 2 : 0);
    if (op >= 2 && r != 2) r = 1 - r;
    return r;
  endfunction

  task automatic send(string tag);
    logic [L-1:0] ev, eu;
    for (int l = 0; l < L; l++) begin
      int a, b, r;
      a = code(a_val[l], a_unk[l]);
      b = code(b_val[l], b_unk[l]);
      if (l != 0) begin
        a = apply_mask(a, a_m1[l], a_m2[l]);
        b = apply_mask(b, b_m1[l], b_m2[l]);
      end
      r = gate(int'(gate_sel), a, b);
      if (l != 0 && fn_lanes[l]) r = gate(int'(fn_sel), a, b);
      if (l != 0) r = apply_mask(r, y_m1[l], y_m2[l]);
      ev[l] = (r == 1);
      eu[l] = (r == 2);
    end
    in_valid = 1'b1;
    #3;
    while (!in_ready) begin
      @(negedge clk);
      #3;
    end
    @(posedge clk);
    exp_q.push_back({eu, ev});
    tag_q.push_back(tag);
    #1 in_valid = 1'b0;
    @(negedge clk);
    #2;
    check(out_valid === 1'b1, "R9 latency", {31'd0, out_valid}, {31'd0, 1'b1});
    @(negedge clk);
  endtask

  task automatic clear_faults();
    a_m1 = '0; a_m2 = '0; b_m1 = '0; b_m2 = '0;
    y_m1 = '0; y_m2 = '0; fn_lanes = '0; fn_sel = '0;
  endtask

  // lanes 0..8 get all 3x3 operand combos, lane 9 a non-canonical X
  task automatic load_combos();
    for (int l = 0; l < L; l++) begin
      int ca, cb;
      ca = (l < 9) ? l / 3 : (l * 7) % 3;
      cb = (l < 9) ? l % 3 : (l * 5) % 3;
      a_val[l] = (ca == 1) || (l == 9);
      a_unk[l] = (ca == 2) || (l == 9);
      b_val[l] = (cb == 1);
      b_unk[l] = (cb == 2);
    end
  endtask

  // monitor / scoreboard
  initial begin
    logic       prev_stall;
    logic [2*L-1:0] prev_out;
    prev_stall = 1'b0;
    prev_out = '0;
    forever begin
      @(negedge clk);
      #1 out_ready = stall_en ? 1'($urandom % 2) : 1'b1;
      #1;
      if (!rst) begin
        check(in_ready === (!out_valid || out_ready), "R10 in_ready",
              {30'd0, out_valid, in_ready}, {30'd0, out_valid, (!out_valid || out_ready)});
        if (prev_stall)
          check(out_valid === 1'b1 && {y_unk, y_val} === prev_out, "R10 hold",
                {y_unk, y_val}, prev_out);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R9 extra result", {y_unk, y_val}, '0);
          end else begin
            logic [2*L-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({y_unk, y_val} === e, t, {y_unk, y_val}, e);
            check((y_val & y_unk) == '0, "R1 canonical", {y_unk, y_val}, e);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_out = {y_unk, y_val};
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R10 reset",
          {30'd0, out_valid, in_ready}, {30'd0, 1'b0, 1'b1});
    @(negedge clk);

    // R2 R3 R4 R1: truth tables, no faults
    clear_faults();
    load_combos();
    gate_sel = 2'd0; send("R2 AND table");
    gate_sel = 2'd1; send("R3 OR table");
    gate_sel = 2'd2; send("R4 NAND table");
    gate_sel = 2'd3; send("R4 NOR table");
    a_val = '1; a_unk = '1; b_val = '0; b_unk = '0;
    gate_sel = 2'd0; send("R1 X with stray value bit AND 0");
    b_val = '1; send("R1 X with stray value bit AND 1");

    // R5 pin faults, each code on its own lanes
    load_combos();
    gate_sel = 2'd1;
    a_m1 = 16'h0F0A; a_m2 = 16'h0A06;
    b_m1 = 16'h3300; b_m2 = 16'h5050;
    send("R5 pin masks OR");
    gate_sel = 2'd2; send("R5 pin masks NAND");

    // R7 R6 functional fault then output mask on the same lane
    clear_faults(); load_combos();
    gate_sel = 2'd0; fn_sel = 2'd3; fn_lanes = 16'h0008;
    send("R7 functional lane");
    y_m1 = 16'h0008; y_m2 = 16'h0008;
    send("R6 output SA1 over functional");
    y_m1 = 16'h00F8; y_m2 = 16'h0050;
    send("R6 output masks");

    // R11 several faults sharing lanes
    clear_faults(); load_combos();
    gate_sel = 2'd3; a_m1 = 16'h0024; a_m2 = 16'h0004;
    b_m2 = 16'h0024; fn_lanes = 16'h0020; fn_sel = 2'd1; y_m2 = 16'h0004;
    send("R11 combined faults");

    // R8 lane 0 ignores all masks
    load_combos();
    a_m1 = '1; a_m2 = '1; b_m1 = '1; b_m2 = '0; y_m1 = '0; y_m2 = '1;
    fn_lanes = '1; fn_sel = 2'd2; gate_sel = 2'd1;
    send("R8 lane0 guard");

    // random traffic with back-pressure
    stall_en = 1'b1;
    for (int k = 0; k < 60; k++) begin
      gate_sel = 2'($urandom); fn_sel = 2'($urandom);
      a_val = L'($urandom); a_unk = L'($urandom); b_val = L'($urandom); b_unk = L'($urandom);
      a_m1 = L'($urandom) & L'($urandom); a_m2 = L'($urandom);
      b_m1 = L'($urandom) & L'($urandom); b_m2 = L'($urandom);
      y_m1 = L'($urandom) & L'($urandom); y_m2 = L'($urandom) & L'($urandom);
      fn_lanes = L'(1) << ($urandom % L);
      send("R11 R10 random");
    end
    stall_en = 1'b0;
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R9 all results out", 32'(exp_q.size()), '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule